// File: doc/BRIEF.md
# Event Counter Performance Monitor

This block is a small performance monitoring unit that sits beside a processor core. It keeps a bank of 32-bit event counters and one free-running cycle counter. Each event counter watches one line of a 64-wide vector of event pulses, chosen by a per-counter type register. A privilege filter in that register can silence the counter while the core runs in privileged or in user mode.

Software reaches the counters through a word-addressed register bus. Type and count registers are not mapped one by one. A select register picks a counter, and two shared access registers then act on the counter it picks. Counter enables and overflow interrupt enables are each changed through a pair of registers: one sets bits and the other clears them. Every counter that wraps from all ones to zero raises a sticky overflow flag. The single interrupt line is driven from the flags whose interrupt enable is set.

Software that wants an interrupt every N events preloads a counter with the two's complement of its period. The wrap then falls after a fixed number of events. A bus-side user flag lets the block refuse register traffic from unprivileged code until a privileged access unlocks it.

Top module: `evmon_top`

## Requirements
- R1: Bit 0 of the control register (word address 0) is the master enable. While it is 0, no event counter and not the cycle counter advances, whatever the per-counter enables say.
- R2: Bit 3 of the control register turns on divide-by-64. With it set, the cycle counter (word address 9) advances once per 64 `cyc_pulse` cycles. With it clear, the cycle counter advances on every pulse.
- R3: The event number sits in type register bits 7:0. An enabled counter adds one in each cycle where `evt_pulse[event]` is high. An event number of 64 or more never counts.
- R4: Type register bit 31 stops the counter while `core_priv` is 1. Bit 30 stops it while `core_priv` is 0.
- R5: The select register is at word address 6. The type and count access registers are at 7 and 8, and they act on the selected counter. When the select value is at or beyond `NUM_CNT`, both access registers read zero and ignore writes.
- R6: Counter enables are set by writing ones to word address 1 and cleared by writing ones to word address 2. Both addresses read back the enable mask. Bit i is event counter i and bit 31 is the cycle counter. Zero bits, and bits with no counter behind them, have no effect.
- R7: Overflow interrupt enables work the same way, with the set register at word address 3 and the clear register at word address 4.
- R8: The overflow register is at word address 5 and uses the same bit layout as the enables. A bit becomes 1 when its counter wraps from all ones to zero, and it holds until a 1 is written to it. A wrap in the same cycle as such a write leaves the flag set.
- R9: Word addresses 10 and 11 are read-only. Together they report the implemented-event map `IMPL_MAP`: event n appears at bit n mod 32 of register 10 + n div 32.
- R10: `irq` is high exactly while some overflow flag and its interrupt enable are both 1.
- R11: The user-access register is at word address 12, bit 0, and resets to 0. While it is 0, accesses with `bus_user` high read zero and change nothing. Writes to this register with `bus_user` high are always ignored.
- R12: When a software write to the count register and a counted event land on the same counter in the same cycle, the written value is kept.
- R13: After reset every register, counter and flag is 0, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_user | input | 1 | Access comes from user mode |
| bus_rdata | output | 32 | Read data, valid in the same cycle as `bus_rd`, zero otherwise |
| core_priv | input | 1 | Core is in privileged mode |
| evt_pulse | input | NUM_EVT | One-cycle event pulses, indexed by event number |
| cyc_pulse | input | 1 | Cycle tick for the cycle counter |
| irq | output | 1 | Overflow interrupt |

## Verification
The cases hardest to reach from the ports are two collisions: a wrap that arrives in the same cycle as a software clear of its flag, and an event that arrives in the same cycle as a software write to the count. The bench reaches both by preloading a counter one step short of its wrap. It then drives the bus write and the event pulse on the same clock edge. The divide-by-64 path needs long runs of cycle pulses, so the bench sends 130 of them and checks that the count rises by exactly two. Random event and privilege patterns then run against four counters with random configurations, and the bench compares the final counts with its own model.

// File: rtl/evmon_pkg.sv
package evmon_pkg;

    localparam int DW = 32;

    typedef enum logic [3:0] {
        A_CTRL    = 4'd0,
        A_CEN_SET = 4'd1,
        A_CEN_CLR = 4'd2,
        A_IEN_SET = 4'd3,
        A_IEN_CLR = 4'd4,
        A_OVF     = 4'd5,
        A_SEL     = 4'd6,
        A_TYPE    = 4'd7,
        A_COUNT   = 4'd8,
        A_CYC     = 4'd9,
        A_MAP_LO  = 4'd10,
        A_MAP_HI  = 4'd11,
        A_UEN     = 4'd12
    } reg_addr_e;

    typedef struct packed {
        logic       no_priv;
        logic       no_user;
        logic [21:0] rsvd;
        logic [7:0] evt;
    } evtype_t;

    localparam int CYC_BIT   = 31;
    localparam int CTRL_EN   = 0;
    localparam int CTRL_DIV  = 3;

endpackage

// File: rtl/evmon_counter.sv
module evmon_counter
    import evmon_pkg::*;
#(
    parameter int NEVT = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            core_priv,
    input  logic [NEVT-1:0] evt_pulse,
    input  logic            type_we,
    input  evtype_t         type_wd,
    input  logic            cnt_we,
    input  logic [DW-1:0]   cnt_wd,
    output evtype_t         type_q,
    output logic [DW-1:0]   cnt_q,
    output logic            wrap
);
    localparam int EIW = $clog2(NEVT);

    logic in_range;
    logic hit;
    logic mode_ok;
    logic inc;

    always_comb begin
        in_range = ({24'd0, type_q.evt} < NEVT);
        hit      = in_range && evt_pulse[type_q.evt[EIW-1:0]];
        mode_ok  = core_priv ? !type_q.no_priv : !type_q.no_user;
        inc      = run && hit && mode_ok;
        wrap     = inc && !cnt_we && (&cnt_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            type_q <= '0;
        end else if (type_we) begin
            type_q <= type_wd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_we) begin
            cnt_q <= cnt_wd;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/evmon_cycle.sv
module evmon_cycle
    import evmon_pkg::*;
#(
    parameter int DIVW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          div_en,
    input  logic          cyc_pulse,
    input  logic          we,
    input  logic [DW-1:0] wd,
    output logic [DW-1:0] cnt_q,
    output logic          wrap
);
    logic [DIVW-1:0] pre_q;
    logic            step;

    always_comb begin
        step = run && cyc_pulse && (!div_en || (&pre_q));
        wrap = step && !we && (&cnt_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!div_en) begin
            pre_q <= '0;
        end else if (run && cyc_pulse) begin
            pre_q <= pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (we) begin
            cnt_q <= wd;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/evmon_top.sv
module evmon_top
    import evmon_pkg::*;
#(
    parameter int          NUM_CNT  = 4,
    parameter int          NUM_EVT  = 64,
    parameter int          DIV_LOG  = 6,
    parameter logic [63:0] IMPL_MAP = 64'h0000_00FF_3FFF_FFFF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [3:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    input  logic               bus_user,
    output logic [31:0]        bus_rdata,
    input  logic               core_priv,
    input  logic [NUM_EVT-1:0] evt_pulse,
    input  logic               cyc_pulse,
    output logic               irq
);
    localparam int          SEL_W    = 5;
    localparam logic [31:0] CNT_MASK = (32'h1 << CYC_BIT) | ((32'h1 << NUM_CNT) - 32'h1);

    logic               ctrl_en, ctrl_div, user_en;
    logic [31:0]        cen, ien, ovf;
    logic [SEL_W-1:0]   sel;
    logic               acc_ok, wr, rd, sel_valid;
    logic [31:0]        wrap_v, rd_val, w1c;
    logic [NUM_CNT-1:0] cnt_wrap;
    logic               cyc_wrap;
    logic [DW-1:0]      cyc_val;
    logic [DW-1:0]      sel_cnt;
    evtype_t            sel_type;
    evtype_t            type_wd;
    evtype_t            type_arr [NUM_CNT];
    logic [NUM_CNT*DW-1:0] cnt_flat;

    always_comb begin
        acc_ok    = !bus_user || user_en;
        wr        = bus_wr && acc_ok;
        rd        = bus_rd && acc_ok;
        sel_valid = ({27'd0, sel} < NUM_CNT);
        type_wd   = '{no_priv: bus_wdata[31], no_user: bus_wdata[30],
                      rsvd: 22'd0, evt: bus_wdata[7:0]};
    end

    // Event counter bank
    generate
        for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
            logic [DW-1:0] cv;
            evmon_counter #(.NEVT(NUM_EVT)) u_cnt (
                .clk       (clk),
                .rst_n     (rst_n),
                .run       (ctrl_en && cen[i]),
                .core_priv (core_priv),
                .evt_pulse (evt_pulse),
                .type_we   (wr && (bus_addr == A_TYPE) && ({27'd0, sel} == i)),
                .type_wd   (type_wd),
                .cnt_we    (wr && (bus_addr == A_COUNT) && ({27'd0, sel} == i)),
                .cnt_wd    (bus_wdata),
                .type_q    (type_arr[i]),
                .cnt_q     (cv),
                .wrap      (cnt_wrap[i])
            );
            assign cnt_flat[i*DW +: DW] = cv;
        end
    endgenerate

    evmon_cycle #(.DIVW(DIV_LOG)) u_cyc (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (ctrl_en && cen[CYC_BIT]),
        .div_en    (ctrl_div),
        .cyc_pulse (cyc_pulse),
        .we        (wr && (bus_addr == A_CYC)),
        .wd        (bus_wdata),
        .cnt_q     (cyc_val),
        .wrap      (cyc_wrap)
    );

    always_comb begin
        wrap_v = '0;
        for (int i = 0; i < NUM_CNT; i++) begin
            wrap_v[i] = cnt_wrap[i];
        end
        wrap_v[CYC_BIT] = cyc_wrap;
        w1c = (wr && (bus_addr == A_OVF)) ? bus_wdata : 32'd0;
    end

    // Control and status registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_en  <= 1'b0;
            ctrl_div <= 1'b0;
            cen      <= '0;
            ien      <= '0;
            ovf      <= '0;
            sel      <= '0;
            user_en  <= 1'b0;
        end else begin
            ovf <= (ovf & ~w1c) | wrap_v;
            if (wr) begin
                unique case (reg_addr_e'(bus_addr))
                    A_CTRL: begin
                        ctrl_en  <= bus_wdata[CTRL_EN];
                        ctrl_div <= bus_wdata[CTRL_DIV];
                    end
                    A_CEN_SET: cen <= cen | (bus_wdata & CNT_MASK);
                    A_CEN_CLR: cen <= cen & ~bus_wdata;
                    A_IEN_SET: ien <= ien | (bus_wdata & CNT_MASK);
                    A_IEN_CLR: ien <= ien & ~bus_wdata;
                    A_SEL:     sel <= bus_wdata[SEL_W-1:0];
                    A_UEN:     if (!bus_user) user_en <= bus_wdata[0];
                    default: ;
                endcase
            end
        end
    end

    // Selected counter view
    always_comb begin
        sel_cnt  = '0;
        sel_type = '0;
        for (int i = 0; i < NUM_CNT; i++) begin
            if ({27'd0, sel} == i) begin
                sel_cnt  = cnt_flat[i*DW +: DW];
                sel_type = type_arr[i];
            end
        end
    end

    always_comb begin
        rd_val = '0;
        unique case (reg_addr_e'(bus_addr))
            A_CTRL:    rd_val = {28'd0, ctrl_div, 2'd0, ctrl_en};
            A_CEN_SET,
            A_CEN_CLR: rd_val = cen;
            A_IEN_SET,
            A_IEN_CLR: rd_val = ien;
            A_OVF:     rd_val = ovf;
            A_SEL:     rd_val = {27'd0, sel};
            A_TYPE:    rd_val = sel_valid ? sel_type : 32'd0;
            A_COUNT:   rd_val = sel_valid ? sel_cnt : 32'd0;
            A_CYC:     rd_val = cyc_val;
            A_MAP_LO:  rd_val = IMPL_MAP[31:0];
            A_MAP_HI:  rd_val = IMPL_MAP[63:32];
            A_UEN:     rd_val = {31'd0, user_en};
            default:   rd_val = '0;
        endcase
        bus_rdata = rd ? rd_val : 32'd0;
    end

    assign irq = |(ovf & ien);

endmodule

// File: rtl/evmon_chk.sv
module evmon_chk #(
    parameter int NUM_CNT = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ctrl_en,
    input logic                 bus_wr,
    input logic                 bus_rd,
    input logic                 bus_user,
    input logic                 user_en,
    input logic [NUM_CNT*32-1:0] cnt_flat,
    input logic [31:0]          cyc_val,
    input logic [31:0]          cen,
    input logic [31:0]          ien,
    input logic [31:0]          ovf,
    input logic [4:0]           sel,
    input logic                 irq,
    input logic [31:0]          bus_rdata
);
    AST_HALT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_en && !bus_wr) |=> ($stable(cnt_flat) && $stable(cyc_val))); // R1

    AST_STICKY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ((ovf & $past(ovf)) == $past(ovf))); // R8

    AST_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ovf != 32'd0)); // R10

    AST_USER_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_user && !user_en && bus_rd) |-> (bus_rdata == 32'd0)); // R11

    AST_USER_WRITE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_user && !user_en && bus_wr) |=> ($stable(cen) && $stable(ien) &&
        $stable(sel) && $stable(ctrl_en) && $stable(user_en))); // R11

endmodule

bind evmon_top evmon_chk #(.NUM_CNT(NUM_CNT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_en   (ctrl_en),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_user  (bus_user),
    .user_en   (user_en),
    .cnt_flat  (cnt_flat),
    .cyc_val   (cyc_val),
    .cen       (cen),
    .ien       (ien),
    .ovf       (ovf),
    .sel       (sel),
    .irq       (irq),
    .bus_rdata (bus_rdata)
);

// File: tb/tb_evmon_top.sv
`timescale 1ns/1ps
module tb_evmon_top;
    localparam logic [63:0] MAP = 64'hA5A5_0000_FFFF_1234;
    localparam logic [3:0] CTRL = 4'd0, CSET = 4'd1, CCLR = 4'd2, ISET = 4'd3,
                           ICLR = 4'd4, OVF = 4'd5, SEL = 4'd6, TYP = 4'd7,
                           CNT = 4'd8, CYC = 4'd9, MLO = 4'd10, MHI = 4'd11,
                           UEN = 4'd12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_user = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        core_priv = 1'b0;
    logic [63:0] evt_pulse = '0;
    logic        cyc_pulse = 1'b0;
    logic        irq;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    evmon_top #(.NUM_CNT(4), .NUM_EVT(64), .DIV_LOG(6), .IMPL_MAP(MAP)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_user(bus_user),
        .bus_rdata(bus_rdata), .core_priv(core_priv), .evt_pulse(evt_pulse),
        .cyc_pulse(cyc_pulse), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input bit u = 1'b0);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_user = u;
        @(negedge clk);
        bus_wr = 1'b0; bus_user = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d, input bit u = 1'b0);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a; bus_user = u;
        #1 d = bus_rdata;
        bus_rd = 1'b0; bus_user = 1'b0;
    endtask

    task automatic step(input logic [63:0] e, input logic p, input logic c);
        @(negedge clk);
        evt_pulse = e; core_priv = p; cyc_pulse = c;
        @(posedge clk);
        #1 evt_pulse = '0; cyc_pulse = 1'b0;
    endtask

    task automatic rd_cnt(input int idx, output logic [31:0] d);
        wr(SEL, idx);
        rd(CNT, d);
    endtask

    function automatic bit counts(input logic [63:0] e, input logic p,
                                  input int ev, input bit np, input bit nu);
        return (ev < 64) && e[ev] && (p ? !np : !nu);
    endfunction

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int ev[4];
        bit np[4], nu[4];
        int exp_c[4];
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R13 reset state
        rd(CTRL, v); check("R13 ctrl", v, 0);
        rd(CSET, v); check("R13 cen", v, 0);
        rd(OVF, v);  check("R13 ovf", v, 0);
        rd(CNT, v);  check("R13 count0", v, 0);
        rd(CYC, v);  check("R13 cyc", v, 0);
        check("R13 irq", {31'd0, irq}, 0);

        // R9 implemented-event map
        rd(MLO, v); check("R9 map lo", v, MAP[31:0]);
        rd(MHI, v); check("R9 map hi", v, MAP[63:32]);

        // R1 master off, R3 basic counting
        wr(SEL, 0); wr(TYP, 5); wr(CSET, 1);
        step(64'h20, 1'b1, 1'b0);
        rd(CNT, v); check("R1 no count when master off", v, 0);
        wr(CTRL, 1);
        repeat (3) step(64'h20, 1'b1, 1'b0);
        step(64'h10, 1'b1, 1'b0);
        rd(CNT, v); check("R3 counts selected event", v, 3);
        rd(TYP, v); check("R3 type readback", v, 5);

        // R4 privilege filters
        wr(TYP, 32'h8000_0005);
        step(64'h20, 1'b1, 1'b0);
        rd(CNT, v); check("R4 bit31 blocks privileged", v, 3);
        step(64'h20, 1'b0, 1'b0);
        rd(CNT, v); check("R4 bit31 allows user", v, 4);
        wr(TYP, 32'h4000_0005);
        step(64'h20, 1'b0, 1'b0);
        rd(CNT, v); check("R4 bit30 blocks user", v, 4);
        step(64'h20, 1'b1, 1'b0);
        rd(CNT, v); check("R4 bit30 allows privileged", v, 5);

        // R3 event number out of range
        wr(TYP, 70);
        step('1, 1'b1, 1'b0);
        rd(CNT, v); check("R3 event >=64 never counts", v, 5);

        // R12 write beats simultaneous event
        wr(TYP, 5);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = CNT; bus_wdata = 100; evt_pulse = 64'h20;
        @(negedge clk);
        bus_wr = 1'b0; evt_pulse = '0;
        rd(CNT, v); check("R12 write priority", v, 100);

        // R6 enable set/clear
        wr(CSET, 32'h6); wr(CCLR, 32'h2);
        rd(CCLR, v); check("R6 set/clear mask", v, 32'h5);
        wr(CSET, 32'hFFFF_FFFF);
        rd(CSET, v); check("R6 only implemented bits", v, 32'h8000_000F);
        wr(CCLR, 32'hFFFF_FFFF); wr(CSET, 32'h1);

        // R5 out-of-range select
        wr(SEL, 9); wr(TYP, 3); wr(CNT, 77);
        rd(TYP, v); check("R5 type reads zero beyond bank", v, 0);
        rd(CNT, v); check("R5 count reads zero beyond bank", v, 0);
        rd_cnt(0, v); check("R5 write beyond bank ignored", v, 100);

        // R8 / R7 / R10 overflow and interrupt
        wr(SEL, 1); wr(TYP, 2); wr(CNT, 32'hFFFF_FFFE);
        wr(CSET, 32'h2); wr(ISET, 32'h2);
        step(64'h4, 1'b1, 1'b0);
        rd(OVF, v); check("R8 no flag before wrap", v, 0);
        step(64'h4, 1'b1, 1'b0);
        rd(OVF, v); check("R8 flag on wrap", v, 32'h2);
        rd(CNT, v); check("R8 count wrapped", v, 0);
        check("R10 irq on enabled flag", {31'd0, irq}, 1);
        wr(OVF, 32'h0);
        rd(OVF, v); check("R8 zero write keeps flag", v, 32'h2);
        wr(ICLR, 32'h2);
        rd(ISET, v); check("R7 ien cleared", v, 0);
        check("R10 irq off with ien clear", {31'd0, irq}, 0);
        wr(ISET, 32'h2);
        check("R7 irq back with ien set", {31'd0, irq}, 1);
        wr(OVF, 32'h2);
        rd(OVF, v); check("R8 W1C clears", v, 0);
        check("R10 irq off after clear", {31'd0, irq}, 0);
        wr(CNT, 32'hFFFF_FFFF);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = OVF; bus_wdata = '1; evt_pulse = 64'h4;
        @(negedge clk);
        bus_wr = 1'b0; evt_pulse = '0;
        rd(OVF, v); check("R8 wrap beats clear", v, 32'h2);
        wr(OVF, '1); wr(ICLR, '1);

        // R2 cycle counter and divider
        wr(CSET, 32'h8000_0000);
        repeat (10) step('0, 1'b1, 1'b1);
        rd(CYC, v); check("R2 cycle counts every pulse", v, 10);
        wr(CTRL, 32'h9);
        repeat (130) step('0, 1'b1, 1'b1);
        rd(CYC, v); check("R2 divide by 64", v, 12);
        wr(CTRL, 0);
        repeat (5) step('0, 1'b1, 1'b1);
        rd(CYC, v); check("R1 cycle stops when master off", v, 12);
        wr(CTRL, 1);

        // R11 user access lock
        rd(CTRL, v, 1'b1); check("R11 locked user read zero", v, 0);
        wr(CTRL, 0, 1'b1);
        rd(CTRL, v); check("R11 locked user write ignored", v, 1);
        wr(UEN, 1, 1'b1);
        rd(UEN, v); check("R11 user cannot unlock", v, 0);
        wr(UEN, 1);
        rd(CTRL, v, 1'b1); check("R11 unlocked user read", v, 1);
        wr(UEN, 0, 1'b1);
        rd(UEN, v); check("R11 user cannot relock", v, 1);
        wr(UEN, 0);

        // Random traffic on the event bank (R3, R4)
        wr(CCLR, '1);
        for (int i = 0; i < 4; i++) begin
            ev[i] = int'($urandom_range(0, 7));
            np[i] = 1'($urandom_range(0, 1));
            nu[i] = 1'($urandom_range(0, 1));
            exp_c[i] = 0;
            wr(SEL, i);
            wr(TYP, {np[i], nu[i], 22'd0, 8'(ev[i])});
            wr(CNT, 0);
        end
        wr(CSET, 32'hF);
        for (int k = 0; k < 300; k++) begin
            logic [63:0] e;
            logic p;
            e = {56'd0, 8'($urandom)};
            p = 1'($urandom);
            for (int i = 0; i < 4; i++)
                if (counts(e, p, ev[i], np[i], nu[i])) exp_c[i]++;
            step(e, p, 1'b0);
        end
        for (int i = 0; i < 4; i++) begin
            rd_cnt(i, v);
            check("R3 R4 random bank count", v, exp_c[i]);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule